// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block decides the control-flow outcome of a register-indirect branch in a 32-bit load-store processor with a 32-entry general register file. It is handed the decoded opcode, a 3-bit condition selector taken from the low end of the instruction's modifier field, the destination register index of the link, the already-incremented program counter, and two register values. The first register value is the candidate branch target. The second is the value the condition inspects. From these it produces the next program counter, a taken flag, and a link write request made of an enable, a register index and the return address.

Two opcodes are recognised. The plain conditional branch uses opcode 8. The branch-with-link variant uses opcode 9. Both share one condition encoding. A taken branch always jumps to the target register's contents. The link variant writes the incremented program counter into the destination register whether or not the jump happens, so a link with the "never" condition acts as a plain save of the return address. All outputs pass through one register stage that is cleared by a synchronous active-low reset. The register file, fetch and any pipelining around the block belong to the surrounding core.

Top module: `bcu_branch_link_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero after that edge: `next_pc`, `taken`, `link_we`, `link_idx` and `link_data`.
- R2: When opcode 8 or 9 is presented with a satisfied condition, `taken` is 1 and `next_pc` equals `target_val`.
- R3: Condition code 3'b000 is never satisfied, and condition code 3'b001 is always satisfied.
- R4: Condition code 3'b010 is satisfied when `test_val` is zero. Condition code 3'b011 is satisfied when `test_val` is nonzero.
- R5: Condition code 3'b100 is satisfied when the top bit of `test_val` is 0. Condition code 3'b101 is satisfied when that bit is 1.
- R6: Condition codes 3'b110 and 3'b111 are never satisfied.
- R7: When the branch is not taken, `taken` is 0 and `next_pc` equals `pc_inc`.
- R8: For opcode 9, `link_we` is 1 regardless of the condition, with `link_idx` equal to `link_dst` and `link_data` equal to `pc_inc`. For opcode 8, `link_we` is 0.
- R9: For any opcode other than 8 and 9, `taken` and `link_we` are both 0 and `next_pc` equals `pc_inc`.
- R10: Every output reflects the inputs sampled at the preceding rising edge. Outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| opcode | input | 5 | Decoded operation code (8 = branch, 9 = branch with link) |
| cond_sel | input | 3 | Condition selector, the three lowest instruction bits |
| link_dst | input | 5 | Index of the register that receives the return address |
| pc_inc | input | 32 | Program counter already advanced past this instruction |
| target_val | input | 32 | Contents of the target register |
| test_val | input | 32 | Contents of the register the condition tests |
| next_pc | output | 32 | Program counter to fetch from next |
| taken | output | 1 | The branch redirects the program counter |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Register index for the return-address write |
| link_data | output | 32 | Return address to be written |

## Verification
Every condition code is driven with test values of zero, one, all ones, only the top bit set and just below it. These values separate an equality-to-zero test from a sign test, and a test of the top bit from a test of some other bit. Each of these is run under opcode 8, opcode 9, and opcodes next to them (7, 10, 0, 31), which shows that the link write depends only on the opcode and that the jump is confined to the two branch opcodes. Random stimulus mixes the same opcode classes with target and program-counter values that are always distinct. A `next_pc` taken from the wrong source therefore cannot match by accident. One directed case samples the outputs between edges to show the register stage holds them.

// File: rtl/bcu_pkg.sv
// Package: shared encodings for the branch and link unit.
// Assumes the condition selector is exactly three bits wide.
package bcu_pkg;

    localparam int COND_W = 3;

    // Condition selector values; codes 6 and 7 are reserved and never hit.
    typedef enum logic [COND_W-1:0] {
        COND_NEVER   = 3'd0,
        COND_ALWAYS  = 3'd1,
        COND_ZERO    = 3'd2,
        COND_NONZERO = 3'd3,
        COND_SIGNCLR = 3'd4,
        COND_SIGNSET = 3'd5,
        COND_RSVD6   = 3'd6,
        COND_RSVD7   = 3'd7
    } cond_e;

    // Class of the presented opcode as seen by this unit.
    typedef enum logic [1:0] {
        KIND_OTHER  = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_LINK   = 2'd2
    } op_kind_e;

endpackage

// File: rtl/bcu_cond_eval.sv
// Module: bcu_cond_eval
// Evaluates the 3-bit branch condition against the tested register value.
// Assumes two's complement data; the sign is the most significant bit.
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [COND_W-1:0] cond_sel,
    input  logic [XLEN-1:0]   test_val,
    output logic              cond_hit
);

    logic is_zero;
    logic sign_bit;

    // Flags derived from the tested value.
    always_comb begin
        is_zero  = (test_val == '0);
        sign_bit = test_val[XLEN-1];
    end

    // Selects the flag that the condition code asks for.
    always_comb begin
        unique case (cond_e'(cond_sel))
            COND_NEVER:   cond_hit = 1'b0;
            COND_ALWAYS:  cond_hit = 1'b1;
            COND_ZERO:    cond_hit = is_zero;
            COND_NONZERO: cond_hit = !is_zero;
            COND_SIGNCLR: cond_hit = !sign_bit;
            COND_SIGNSET: cond_hit = sign_bit;
            default:      cond_hit = 1'b0;
        endcase
    end

    // Reserved codes must never report a hit (R6).
    always_comb begin
        if (cond_sel == 3'd6 || cond_sel == 3'd7) begin
            p_reserved_quiet_r6: assert (!cond_hit || $isunknown(cond_sel))
                else $error("reserved condition reported a hit");
        end
    end

endmodule

// File: rtl/bcu_decide.sv
// Module: bcu_decide
// Classifies the opcode and forms the unregistered next PC and link request.
// Assumes the condition hit is already evaluated; it is ignored for non-branch opcodes.
module bcu_decide
    import bcu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OP_W   = 5,
    parameter int IDX_W  = 5,
    parameter int OP_BR  = 8,
    parameter int OP_BRL = 9
) (
    input  logic [OP_W-1:0]  opcode,
    input  logic             cond_hit,
    input  logic [IDX_W-1:0] link_dst,
    input  logic [XLEN-1:0]  pc_inc,
    input  logic [XLEN-1:0]  target_val,
    output logic [XLEN-1:0]  d_next_pc,
    output logic             d_taken,
    output logic             d_link_we,
    output logic [IDX_W-1:0] d_link_idx,
    output logic [XLEN-1:0]  d_link_data
);

    op_kind_e kind;

    // Maps the opcode onto the three classes this unit distinguishes.
    always_comb begin
        if (opcode == OP_W'(OP_BR))       kind = KIND_BRANCH;
        else if (opcode == OP_W'(OP_BRL)) kind = KIND_LINK;
        else                              kind = KIND_OTHER;
    end

    // Chooses between the register target and the sequential PC.
    always_comb begin
        d_taken   = (kind != KIND_OTHER) && cond_hit;
        d_next_pc = d_taken ? target_val : pc_inc;
    end

    // Builds the return-address write; enabled by the link opcode alone.
    always_comb begin
        d_link_we   = (kind == KIND_LINK);
        d_link_idx  = link_dst;
        d_link_data = pc_inc;
    end

    // A jump never originates from an unrelated opcode (R9).
    always_comb begin
        if (!$isunknown(opcode) && opcode != OP_W'(OP_BR) && opcode != OP_W'(OP_BRL)) begin
            p_other_no_jump_r9: assert (!d_taken && !d_link_we)
                else $error("non-branch opcode produced a jump or link");
        end
    end

endmodule

// File: rtl/bcu_out_reg.sv
// Module: bcu_out_reg
// Register stage of configurable width with synchronous active-low clear.
// Assumes the reset value is all zeros.
module bcu_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Captures the decision on each rising edge, clears it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/bcu_branch_link_unit.sv
// Module: bcu_branch_link_unit
// Top of the conditional branch and link unit: condition evaluation, decision
// and one output register stage. Assumes register reads happen outside and
// that pc_inc already points past the current instruction.
module bcu_branch_link_unit
    import bcu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREG   = 32,
    parameter int OP_W   = 5,
    parameter int OP_BR  = 8,
    parameter int OP_BRL = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OP_W-1:0]         opcode,
    input  logic [2:0]              cond_sel,
    input  logic [$clog2(NREG)-1:0] link_dst,
    input  logic [XLEN-1:0]         pc_inc,
    input  logic [XLEN-1:0]         target_val,
    input  logic [XLEN-1:0]         test_val,
    output logic [XLEN-1:0]         next_pc,
    output logic                    taken,
    output logic                    link_we,
    output logic [$clog2(NREG)-1:0] link_idx,
    output logic [XLEN-1:0]         link_data
);

    localparam int IDX_W = $clog2(NREG);
    localparam int PACK_W = XLEN + 1 + 1 + IDX_W + XLEN;

    logic             cond_hit;
    logic [XLEN-1:0]  d_next_pc;
    logic             d_taken;
    logic             d_link_we;
    logic [IDX_W-1:0] d_link_idx;
    logic [XLEN-1:0]  d_link_data;
    logic [PACK_W-1:0] stage_d;
    logic [PACK_W-1:0] stage_q;

    bcu_cond_eval #(.XLEN(XLEN)) u_cond (
        .cond_sel (cond_sel),
        .test_val (test_val),
        .cond_hit (cond_hit)
    );

    bcu_decide #(
        .XLEN   (XLEN),
        .OP_W   (OP_W),
        .IDX_W  (IDX_W),
        .OP_BR  (OP_BR),
        .OP_BRL (OP_BRL)
    ) u_decide (
        .opcode      (opcode),
        .cond_hit    (cond_hit),
        .link_dst    (link_dst),
        .pc_inc      (pc_inc),
        .target_val  (target_val),
        .d_next_pc   (d_next_pc),
        .d_taken     (d_taken),
        .d_link_we   (d_link_we),
        .d_link_idx  (d_link_idx),
        .d_link_data (d_link_data)
    );

    // Packs the decision so one register stage holds it.
    always_comb begin
        stage_d = {d_next_pc, d_taken, d_link_we, d_link_idx, d_link_data};
    end

    bcu_out_reg #(.W(PACK_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stage_d),
        .q     (stage_q)
    );

    // Unpacks the registered decision onto the ports.
    always_comb begin
        {next_pc, taken, link_we, link_idx, link_data} = stage_q;
    end

    // A taken jump lands on the target sampled one edge earlier (R2).
    p_taken_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && taken) |-> (next_pc == $past(target_val)))
        else $error("taken branch left the target");

    // A fall-through continues at the incremented PC (R7).
    p_fallthrough_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken) |-> (next_pc == $past(pc_inc)))
        else $error("fall-through did not use pc_inc");

    // Never and reserved selectors do not jump (R3, R6).
    p_dead_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(cond_sel) == 3'd0 || $past(cond_sel) == 3'd6 ||
                          $past(cond_sel) == 3'd7)) |-> !taken)
        else $error("dead condition code jumped");

    // A link write only follows the link opcode and carries the return address (R8).
    p_link_payload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> ($past(opcode) == OP_W'(OP_BRL) && link_data == $past(pc_inc) &&
                     link_idx == $past(link_dst)))
        else $error("link write with wrong source or payload");

    // The link opcode always requests a write, whatever the condition (R8).
    p_link_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == OP_W'(OP_BRL)) |-> link_we)
        else $error("link opcode dropped its write");

endmodule

// File: tb/bcu_branch_link_unit_tb.sv
// Bench for bcu_branch_link_unit: directed corners plus seeded random vectors.
module bcu_branch_link_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  opcode;
    logic [2:0]  cond_sel;
    logic [4:0]  link_dst;
    logic [31:0] pc_inc;
    logic [31:0] target_val;
    logic [31:0] test_val;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bcu_branch_link_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .cond_sel   (cond_sel),
        .link_dst   (link_dst),
        .pc_inc     (pc_inc),
        .target_val (target_val),
        .test_val   (test_val),
        .next_pc    (next_pc),
        .taken      (taken),
        .link_we    (link_we),
        .link_idx   (link_idx),
        .link_data  (link_data)
    );

    // Condition outcome computed from the requirement text (R3..R6).
    function automatic bit ref_hit(input logic [2:0] c, input logic [31:0] t);
        case (c)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return t == 32'd0;
            3'd3: return t != 32'd0;
            3'd4: return !t[31];
            3'd5: return t[31];
            default: return 1'b0;
        endcase
    endfunction

    // Requirement tag that a vector mainly exercises.
    function automatic string req_tag(input logic [4:0] op, input logic [2:0] c, input bit hit);
        if (op != 5'd8 && op != 5'd9) return "R9";
        if (op == 5'd9 && !hit)       return "R8";
        if (!hit && (c == 3'd6 || c == 3'd7)) return "R6";
        if (!hit)                     return "R7";
        if (c == 3'd2 || c == 3'd3)   return "R4";
        if (c == 3'd4 || c == 3'd5)   return "R5";
        if (c == 3'd1)                return "R3";
        return "R2";
    endfunction

    // Drives one vector at a falling edge and checks it one edge later.
    task automatic apply(input logic [4:0] op, input logic [2:0] c, input logic [4:0] ra,
                         input logic [31:0] pc, input logic [31:0] tgt, input logic [31:0] tv);
        bit is_br   = (op == 5'd8) || (op == 5'd9);
        bit e_taken = is_br && ref_hit(c, tv);
        logic [31:0] e_pc = e_taken ? tgt : pc;
        bit e_we = (op == 5'd9);
        string tag = req_tag(op, c, ref_hit(c, tv));
        opcode = op; cond_sel = c; link_dst = ra;
        pc_inc = pc; target_val = tgt; test_val = tv;
        @(negedge clk);
        vectors++;
        if (next_pc !== e_pc || taken !== e_taken || link_we !== e_we ||
            (e_we && (link_idx !== ra || link_data !== pc))) begin
            fails++;
            $display("FAIL %s op=%0d c=%0d tv=%h: got pc=%h tk=%b we=%b idx=%0d ld=%h exp pc=%h tk=%b we=%b idx=%0d ld=%h",
                     tag, op, c, tv, next_pc, taken, link_we, link_idx, link_data,
                     e_pc, e_taken, e_we, ra, pc);
        end
    endtask

    // Watchdog: an expired run is one failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [5];
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'h7FFF_FFFF;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; opcode = 5'd9; cond_sel = 3'd1; link_dst = 5'd7;
        pc_inc = 32'h1234_5678; target_val = 32'hDEAD_BEE0; test_val = 32'd0;
        @(negedge clk); @(negedge clk);
        // R1: outputs cleared under reset even with a taken link presented.
        vectors++;
        if (next_pc !== 0 || taken !== 0 || link_we !== 0 || link_idx !== 0 || link_data !== 0) begin
            fails++;
            $display("FAIL R1 reset state: got pc=%h tk=%b we=%b idx=%0d ld=%h exp all zero",
                     next_pc, taken, link_we, link_idx, link_data);
        end
        rst_n = 1'b1;

        // Directed: every selector with every corner value, under branch and link opcodes.
        for (int op_i = 0; op_i < 2; op_i++)
            for (int c = 0; c < 8; c++)
                for (int k = 0; k < 5; k++)
                    apply(op_i ? 5'd9 : 5'd8, 3'(c), 5'(c + 3 * k), 32'h0000_1000 + 32'(4 * k),
                          32'h00AB_0000 + 32'(c), corners[k]);

        // Directed R9: neighbouring and extreme opcodes with an always-true selector.
        foreach (corners[k]) begin
            apply(5'd7,  3'd1, 5'd3, 32'h100, 32'h900, corners[k]);
            apply(5'd10, 3'd1, 5'd4, 32'h104, 32'h904, corners[k]);
            apply(5'd0,  3'd1, 5'd5, 32'h108, 32'h908, corners[k]);
            apply(5'd31, 3'd2, 5'd6, 32'h10C, 32'h90C, corners[k]);
        end

        // R10: outputs hold between edges after new inputs are driven.
        apply(5'd8, 3'd1, 5'd1, 32'h2000, 32'h3000, 32'd0);
        opcode = 5'd8; cond_sel = 3'd0; pc_inc = 32'h4444; target_val = 32'h5555;
        #2;
        vectors++;
        if (next_pc !== 32'h3000 || taken !== 1'b1) begin
            fails++;
            $display("FAIL R10 mid-cycle: got pc=%h tk=%b exp pc=%h tk=1", next_pc, taken, 32'h3000);
        end
        @(negedge clk);

        // Random vectors, biased toward the two branch opcodes and to zero/sign corners.
        for (int n = 0; n < 3000; n++) begin
            logic [4:0]  op;
            logic [31:0] tv;
            logic [31:0] pc;
            int sel = $urandom % 4;
            op = (sel == 0) ? 5'd8 : (sel == 1) ? 5'd9 : 5'($urandom);
            tv = ($urandom % 4 == 0) ? corners[$urandom % 5] : $urandom;
            pc = {$urandom, 2'b00} >> 1;
            apply(op, 3'($urandom), 5'($urandom), pc, ~pc, tv);
        end

        // R1 again: reset in mid-run clears a pending link.
        apply(5'd9, 3'd1, 5'd2, 32'h10, 32'h20, 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        vectors++;
        if (next_pc !== 0 || taken !== 0 || link_we !== 0 || link_data !== 0) begin
            fails++;
            $display("FAIL R1 mid-run reset: got pc=%h tk=%b we=%b ld=%h exp all zero",
                     next_pc, taken, link_we, link_data);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule